// File: doc/BRIEF.md
# Charge-Path Protection Delay Controller

This block owns the charge-enable output of a two-cell battery protector. It receives synchronous comparator flags: a cell above the overcharge threshold, both cells at or below the release threshold, the pack-minus node above the overcurrent threshold, and pack-minus at or below the excessive-charger threshold. It also receives a load-present indication, the level of the discharge output driven by the neighbouring discharge controller, and a test-mode pin. Each fault condition has to hold for a number of 250 µs ticks before it is accepted. Each release condition is qualified in the same way, with its own count.

Two fault states drive the charge output low: overcharge and excessive charger. Overcharge takes precedence. While the discharge output is low, excessive-charger qualification is held off. After an overcharge release with a high-voltage charger still attached, the output stays low while that charger is qualified. The block tells the discharge controller when overcharge is active. During overcharge it also picks the reduced-hysteresis release level whenever a load pulls pack-minus above the overcurrent threshold.

Top module: `chg_path_guard`

## Requirements
- R1: After reset, chgEnable is 1, ovcActive is 0, relLevelHi is 0, and every delay starts from zero.
- R2: cellOverFlag held at 1 for 4000 consecutive ticks (1.0 s) drives chgEnable to 0 and ovcActive to 1. A drop of the flag before that restarts the count.
- R3: In overcharge, the release condition held for 160 ticks (40 ms) returns chgEnable to 1 and ovcActive to 0. The release condition is cellRelFlag=1 with either packAboveOc=0 or loadPresent=1.
- R4: In overcharge, when packAboveOc=1 and loadPresent=0, the block stays in overcharge whatever cellRelFlag does.
- R5: relLevelHi is 1 exactly when ovcActive=1 and packAboveOc=1. Otherwise it is 0, which selects the lower, full-hysteresis release level.
- R6: xchgFlag held at 1 for 6 ticks (1.5 ms) with dischgHigh=1 drives chgEnable to 0. A drop of the flag during the count aborts it.
- R7: In the excessive-charger state, xchgFlag held at 0 for 6 ticks returns chgEnable to 1.
- R8: While dischgHigh=0 the excessive-charger count is held at zero, and chgEnable stays 1. The 6-tick count begins only once dischgHigh is 1.
- R9: When an overcharge release completes while xchgFlag=1, chgEnable stays 0. The excessive-charger count then runs. If the flag drops first, chgEnable returns to 1. If the count completes, the excessive-charger state follows.
- R10: While testMode=1, every delay is one tick.
- R11: If overcharge and excessive-charger qualification complete in the same cycle, or overcharge qualifies during the excessive-charger state, the block enters overcharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time base strobe, one every 250 µs |
| testMode | input | 1 | 1 shortens every delay to one tick |
| cellOverFlag | input | 1 | A cell is above the overcharge threshold |
| cellRelFlag | input | 1 | Both cells are at or below the release threshold |
| packAboveOc | input | 1 | Pack-minus is above the overcurrent threshold |
| loadPresent | input | 1 | A load is connected |
| xchgFlag | input | 1 | Pack-minus is at or below the excessive-charger threshold |
| dischgHigh | input | 1 | The discharge output is high |
| chgEnable | output | 1 | Charge FET enable, 1 allows charging |
| ovcActive | output | 1 | Overcharge state, for the discharge controller |
| relLevelHi | output | 1 | 1 selects the reduced-hysteresis release level |

## Verification
Overcharge qualification and excessive-charger qualification can complete on the same clock. The bench provokes this in test mode by raising cellOverFlag and xchgFlag on the same edge, so both one-tick counts expire together. A behavioural model predicts the result and is compared every cycle, with an explicit check that ovcActive wins. A second collision comes when overcharge qualifies while the excessive-charger release is in progress. The model tracks it, and the bench judges it on chgEnable and ovcActive.

// File: rtl/chgp_pkg.sv
package chgp_pkg;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_OVC  = 2'd1,
    ST_XCHK = 2'd2,
    ST_XCHG = 2'd3
  } chgState_t;

  // strobes from control to the delay datapath
  typedef struct packed {
    logic ovcRun;
    logic ovcClr;
    logic ovcRel;
    logic xRun;
    logic xClr;
    logic xRel;
  } chgStrobe_t;

endpackage

// File: rtl/chgp_delay_cnt.sv
module chgp_delay_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      cnt <= '0;
    end else if (run && tick && (cnt < limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt >= limit);

  assert_clr_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (clr && limit != '0) |=> !done);

endmodule

// File: rtl/chgp_datapath.sv
module chgp_datapath
  import chgp_pkg::*;
#(
  parameter int TICK_US     = 250,
  parameter int OVC_DET_US  = 1000000,
  parameter int OVC_REL_US  = 40000,
  parameter int XCHG_DET_US = 1500,
  parameter int XCHG_REL_US = 1500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       testMode,
  input  chgStrobe_t strb,
  output logic       ovcDone,
  output logic       xDone
);

  localparam int OVC_DET_CNT  = OVC_DET_US / TICK_US;
  localparam int OVC_REL_CNT  = OVC_REL_US / TICK_US;
  localparam int XCHG_DET_CNT = XCHG_DET_US / TICK_US;
  localparam int XCHG_REL_CNT = XCHG_REL_US / TICK_US;
  localparam int MAX_A   = (OVC_DET_CNT > OVC_REL_CNT) ? OVC_DET_CNT : OVC_REL_CNT;
  localparam int MAX_B   = (XCHG_DET_CNT > XCHG_REL_CNT) ? XCHG_DET_CNT : XCHG_REL_CNT;
  localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int NUM_CNT = 2;

  localparam logic [CNT_W-1:0] ONE_TICK = CNT_W'(1);

  logic [NUM_CNT-1:0]            runVec, clrVec, relVec, doneVec;
  logic [NUM_CNT-1:0][CNT_W-1:0] detLim, relLim;

  assign runVec = {strb.xRun, strb.ovcRun};
  assign clrVec = {strb.xClr, strb.ovcClr};
  assign relVec = {strb.xRel, strb.ovcRel};
  assign detLim = {CNT_W'(XCHG_DET_CNT), CNT_W'(OVC_DET_CNT)};
  assign relLim = {CNT_W'(XCHG_REL_CNT), CNT_W'(OVC_REL_CNT)};

  for (genvar g = 0; g < NUM_CNT; g++) begin : gDelay
    logic [CNT_W-1:0] lim;
    always_comb begin
      if (testMode)      lim = ONE_TICK;
      else if (relVec[g]) lim = relLim[g];
      else               lim = detLim[g];
    end
    chgp_delay_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rstN  (rstN),
      .tick  (tick),
      .run   (runVec[g]),
      .clr   (clrVec[g]),
      .limit (lim),
      .done  (doneVec[g])
    );
  end

  assign ovcDone = doneVec[0];
  assign xDone   = doneVec[1];

endmodule

// File: rtl/chgp_control.sv
module chgp_control
  import chgp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cellOverFlag,
  input  logic       cellRelFlag,
  input  logic       packAboveOc,
  input  logic       loadPresent,
  input  logic       xchgFlag,
  input  logic       dischgHigh,
  input  logic       ovcDone,
  input  logic       xDone,
  output chgStrobe_t strb,
  output logic       chgEnable,
  output logic       ovcActive,
  output logic       relLevelHi
);

  chgState_t state, nextState;
  logic relOk, xArm, ovcHit, xHit;

  assign relOk = cellRelFlag && (!packAboveOc || loadPresent);
  assign xArm  = xchgFlag && dischgHigh;

  always_comb begin
    strb.ovcRun = 1'b0;
    strb.ovcRel = 1'b0;
    strb.xRun   = 1'b0;
    strb.xRel   = 1'b0;
    unique case (state)
      ST_NORM, ST_XCHK: begin
        strb.ovcRun = cellOverFlag;
        strb.xRun   = xArm;
      end
      ST_OVC: begin
        strb.ovcRun = relOk;
        strb.ovcRel = 1'b1;
      end
      ST_XCHG: begin
        strb.ovcRun = cellOverFlag;
        strb.xRun   = !xchgFlag;
        strb.xRel   = 1'b1;
      end
      default: ;
    endcase
  end

  assign ovcHit = strb.ovcRun && ovcDone;
  assign xHit   = strb.xRun && xDone;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_NORM: begin
        if (ovcHit)    nextState = ST_OVC;
        else if (xHit) nextState = ST_XCHG;
      end
      ST_OVC: begin
        if (ovcHit) nextState = xchgFlag ? ST_XCHK : ST_NORM;
      end
      ST_XCHK: begin
        if (ovcHit)         nextState = ST_OVC;
        else if (!xchgFlag) nextState = ST_NORM;
        else if (xHit)      nextState = ST_XCHG;
      end
      ST_XCHG: begin
        if (ovcHit)    nextState = ST_OVC;
        else if (xHit) nextState = ST_NORM;
      end
      default: nextState = ST_NORM;
    endcase
  end

  assign strb.ovcClr = !strb.ovcRun || (nextState != state);
  assign strb.xClr   = !strb.xRun || (nextState != state);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_NORM;
    else       state <= nextState;
  end

  assign chgEnable  = (state == ST_NORM);
  assign ovcActive  = (state == ST_OVC);
  assign relLevelHi = ovcActive && packAboveOc;

  assert_ovc_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovcActive) |-> $past(cellOverFlag));

  assert_ovc_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovcActive) |-> $past(cellRelFlag && (!packAboveOc || loadPresent)));

  assert_no_release_unloaded_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ovcActive && packAboveOc && !loadPresent) |=> ovcActive);

  assert_level_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    relLevelHi |-> (ovcActive && packAboveOc));

  assert_xchg_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_XCHG) |-> $past(xchgFlag && dischgHigh));

  assert_xchg_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_XCHG) |-> ($past(!xchgFlag) || ovcActive));

endmodule

// File: rtl/chg_path_guard.sv
module chg_path_guard
  import chgp_pkg::*;
#(
  parameter int TICK_US     = 250,
  parameter int OVC_DET_US  = 1000000,
  parameter int OVC_REL_US  = 40000,
  parameter int XCHG_DET_US = 1500,
  parameter int XCHG_REL_US = 1500
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic testMode,
  input  logic cellOverFlag,
  input  logic cellRelFlag,
  input  logic packAboveOc,
  input  logic loadPresent,
  input  logic xchgFlag,
  input  logic dischgHigh,
  output logic chgEnable,
  output logic ovcActive,
  output logic relLevelHi
);

  chgStrobe_t strb;
  logic ovcDone, xDone;

  chgp_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cellOverFlag (cellOverFlag),
    .cellRelFlag  (cellRelFlag),
    .packAboveOc  (packAboveOc),
    .loadPresent  (loadPresent),
    .xchgFlag     (xchgFlag),
    .dischgHigh   (dischgHigh),
    .ovcDone      (ovcDone),
    .xDone        (xDone),
    .strb         (strb),
    .chgEnable    (chgEnable),
    .ovcActive    (ovcActive),
    .relLevelHi   (relLevelHi)
  );

  chgp_datapath #(
    .TICK_US     (TICK_US),
    .OVC_DET_US  (OVC_DET_US),
    .OVC_REL_US  (OVC_REL_US),
    .XCHG_DET_US (XCHG_DET_US),
    .XCHG_REL_US (XCHG_REL_US)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .testMode (testMode),
    .strb     (strb),
    .ovcDone  (ovcDone),
    .xDone    (xDone)
  );

endmodule

// File: tb/chg_path_guard_tb.sv
module chg_path_guard_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic testMode = 1'b0;
  logic cellOverFlag = 1'b0, cellRelFlag = 1'b0, packAboveOc = 1'b0;
  logic loadPresent = 1'b0, xchgFlag = 1'b0, dischgHigh = 1'b1;
  logic chgEnable, ovcActive, relLevelHi;

  always #4 clk = ~clk;

  chg_path_guard dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .testMode(testMode),
    .cellOverFlag(cellOverFlag), .cellRelFlag(cellRelFlag),
    .packAboveOc(packAboveOc), .loadPresent(loadPresent),
    .xchgFlag(xchgFlag), .dischgHigh(dischgHigh),
    .chgEnable(chgEnable), .ovcActive(ovcActive), .relLevelHi(relLevelHi)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 0;

  // model: 0 normal, 1 overcharge, 2 post-release charger check, 3 excessive charger
  int mState = 0;
  int mOvcTicks = 0;
  int mXTicks = 0;

  always @(negedge clk) tick = ~tick;

  always @(posedge clk) begin
    int lo, lx, ns;
    bit ro, rx, ok;
    cycles++;
    if (!rstN) begin
      mState = 0; mOvcTicks = 0; mXTicks = 0;
    end else begin
      ok = cellRelFlag && (!packAboveOc || loadPresent);
      ro = 0; rx = 0; lo = 4000; lx = 6;
      case (mState)
        0, 2: begin ro = cellOverFlag; rx = xchgFlag && dischgHigh; end
        1: begin ro = ok; lo = 160; end
        default: begin ro = cellOverFlag; rx = !xchgFlag; end
      endcase
      if (testMode) begin lo = 1; lx = 1; end
      ns = mState;
      if (mState == 1) begin
        if (ro && mOvcTicks >= lo) ns = xchgFlag ? 2 : 0;
      end else if (ro && mOvcTicks >= lo) ns = 1;
      else if (mState == 2 && !xchgFlag) ns = 0;
      else if (rx && mXTicks >= lx) ns = (mState == 3) ? 0 : 3;
      if (!ro || ns != mState) mOvcTicks = 0;
      else if (tick && mOvcTicks < lo) mOvcTicks++;
      if (!rx || ns != mState) mXTicks = 0;
      else if (tick && mXTicks < lx) mXTicks++;
      mState = ns;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      bit eC, eO, eS;
      eC = (mState == 0);
      eO = (mState == 1);
      eS = eO && packAboveOc;
      total++;
      if (chgEnable !== eC || ovcActive !== eO || relLevelHi !== eS) begin
        bad++;
        $display("FAIL %s cycle %0d: actual chg=%b ovc=%b sel=%b expected chg=%b ovc=%b sel=%b",
                 curReq, cycles, chgEnable, ovcActive, relLevelHi, eC, eO, eS);
      end
    end
  end

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(input string req, input bit eC, input bit eO);
    total++;
    if (chgEnable !== eC || ovcActive !== eO) begin
      bad++;
      $display("FAIL %s: actual chg=%b ovc=%b expected chg=%b ovc=%b",
               req, chgEnable, ovcActive, eC, eO);
    end
  endtask

  initial begin
    waitC(4);
    rstN = 1'b1;
    waitC(2);
    curReq = "R1";
    expectOut("R1", 1, 0);
    // R2: interrupted count, then full qualification
    curReq = "R2";
    cellOverFlag = 1; waitC(3000);
    cellOverFlag = 0; waitC(4);
    cellOverFlag = 1; waitC(6000);
    expectOut("R2", 1, 0);
    waitC(2100);
    expectOut("R2", 0, 1);
    cellOverFlag = 0;
    // R4 and R5: load absent with pack-minus high blocks release
    curReq = "R4";
    cellRelFlag = 1; packAboveOc = 1; loadPresent = 0;
    waitC(600);
    expectOut("R4", 0, 1);
    curReq = "R5";
    total++;
    if (relLevelHi !== 1'b1) begin bad++; $display("FAIL R5: actual sel=%b expected sel=1", relLevelHi); end
    // R3: load connected allows release
    curReq = "R3";
    loadPresent = 1; waitC(340);
    expectOut("R3", 1, 0);
    packAboveOc = 0; loadPresent = 0; cellRelFlag = 0;
    // R6: aborted then completed excessive-charger detection
    curReq = "R6";
    xchgFlag = 1; waitC(7); xchgFlag = 0; waitC(3);
    expectOut("R6", 1, 0);
    // R8: held off while discharge output low
    curReq = "R8";
    dischgHigh = 0; xchgFlag = 1; waitC(60);
    expectOut("R8", 1, 0);
    dischgHigh = 1; waitC(8);
    expectOut("R8", 1, 0);
    curReq = "R6";
    waitC(10);
    expectOut("R6", 0, 0);
    // R7: release after flag clear
    curReq = "R7";
    xchgFlag = 0; waitC(16);
    expectOut("R7", 1, 0);
    // R9: overcharge release with excessive charger present
    curReq = "R9";
    cellOverFlag = 1; waitC(8020);
    cellOverFlag = 0; xchgFlag = 1; cellRelFlag = 1;
    waitC(400);
    expectOut("R9", 0, 0);
    xchgFlag = 0; waitC(16);
    expectOut("R9", 1, 0);
    cellRelFlag = 0;
    // R10: test mode one-tick delays
    curReq = "R10";
    testMode = 1;
    cellOverFlag = 1; waitC(4);
    expectOut("R10", 0, 1);
    cellOverFlag = 0; cellRelFlag = 1; waitC(4);
    expectOut("R10", 1, 0);
    cellRelFlag = 0;
    // R11: both qualify together, overcharge wins
    curReq = "R11";
    cellOverFlag = 1; xchgFlag = 1; waitC(6);
    expectOut("R11", 0, 1);
    cellOverFlag = 0; xchgFlag = 0; cellRelFlag = 1; waitC(6);
    cellRelFlag = 0;
    // R11: overcharge during excessive-charger state
    xchgFlag = 1; waitC(6);
    expectOut("R11", 0, 0);
    cellOverFlag = 1; waitC(6);
    expectOut("R11", 0, 1);
    cellOverFlag = 0; xchgFlag = 0; testMode = 0;
    waitC(20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog %s: actual cycles=%0d expected completion", curReq, cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule